// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block supervises the link integrity of one twisted-pair repeater port. On the transmit side it measures how long the port transmitter has been idle, in units of a millisecond tick. Once the idle time reaches a fixed threshold, it raises a one-cycle request for the line driver to send a link test pulse. These requests are made in every link state, and a per-port enable bit can mask them.

On the receive side, a silence timer is restarted by every data packet and every received link pulse. With link test enabled, a port in link-pass drops to link-fail if the silence lasts long enough. In link-fail the port is disabled, and the disable output blocks both repeat directions. The port leaves link-fail on one data packet, or on a run of consecutive link pulses in which no pulse gap exceeds the loss timeout. When link test is disabled, link-fail is never entered.

An instance is placed per port, next to the port's receive squelch and transmit driver. The tick input is a single-cycle strobe from a shared millisecond divider.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset the port is in link-fail: `link_ok` is 0, `port_disable` is 1 and `pulse_req` is 0.
- R2: With `tx_active` low, `pulse_req` is high for exactly one cycle in the cycle after the 16th consecutive tick. The idle count then restarts from zero, so the next request follows 16 ticks later.
- R3: Any cycle with `tx_active` high clears the idle count, so a request then needs 16 fresh idle ticks.
- R4: While `pulse_tx_en` is 0, `pulse_req` stays 0.
- R5: Pulse requests are produced whether the port is in link-pass or link-fail.
- R6: In link-pass with `link_test_en` = 1, the 100th tick without any `rx_packet` or `rx_link_pulse` puts the port in link-fail in the following cycle. From then on, `port_disable` is the inverse of `link_ok`.
- R7: With `link_test_en` = 0, `link_ok` is 1 from the next cycle on, whatever the silence. If link test is re-enabled after 100 or more silent ticks, link-fail follows in the next cycle.
- R8: A cycle with `rx_packet` = 1 puts the port in link-pass in the next cycle.
- R9: In link-fail, the fourth consecutive `rx_link_pulse` puts the port in link-pass in the next cycle. The first three pulses leave it in link-fail.
- R10: In link-fail, a silence of 100 ticks between pulses restarts the pulse count, so four further pulses are needed.
- R11: A packet or link pulse arriving in the same cycle as the 100th silent tick cancels the timeout. In link-pass the port stays up, and in link-fail that pulse still counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| tx_active | input | 1 | Port transmitter is sending |
| rx_packet | input | 1 | Strobe: data packet received |
| rx_link_pulse | input | 1 | Strobe: link test pulse received |
| link_test_en | input | 1 | Enable link monitoring for the port |
| pulse_tx_en | input | 1 | Enable link pulse transmission |
| pulse_req | output | 1 | One-cycle request to send a link pulse |
| link_ok | output | 1 | Port is in link-pass |
| port_disable | output | 1 | Port is in link-fail; block repeat |

## Verification
Two events can land in the same cycle: the silence timer reaching its 100th tick, and the arrival of a link pulse. The bench sets this up by running the timer to 99 ticks and then driving a tick together with `rx_link_pulse` in one cycle. It does this twice: in link-fail with three pulses already counted, where the port must come up, and in link-pass, where the port must stay up. The timer must then restart, which is judged by a failure exactly 100 ticks later.

// File: rtl/tplm_pkg.sv
package tplm_pkg;

   typedef enum logic {
      LNK_FAIL = 1'b0,
      LNK_PASS = 1'b1
   } link_state_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/tplm_idle_pulser.sv
module tplm_idle_pulser #(
   parameter int unsigned IDLE_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic tx_active,
   input  logic pulse_tx_en,
   output logic pulse_req
);
   localparam int unsigned CW = tplm_pkg::cnt_width(IDLE_TICKS);
   localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

   generate
      if (IDLE_TICKS < 2) begin : g_bad_idle
         $error("IDLE_TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] idle_cnt;
   logic          wrap;

   assign wrap = ms_tick && !tx_active && (idle_cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_cnt  <= '0;
         pulse_req <= 1'b0;
      end else begin
         if (tx_active) begin
            idle_cnt <= '0;
         end else if (ms_tick) begin
            idle_cnt <= wrap ? '0 : idle_cnt + 1'b1;
         end
         pulse_req <= wrap && pulse_tx_en;
      end
   end

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_req |=> !pulse_req); // R2
   AST_TX_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      tx_active |=> !pulse_req); // R3
   AST_MASK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_tx_en |=> !pulse_req); // R4

endmodule

// File: rtl/tplm_silence_timer.sv
module tplm_silence_timer #(
   parameter int unsigned LOSS_TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic rx_evt,
   output logic hit,
   output logic expired
);
   localparam int unsigned CW = tplm_pkg::cnt_width(LOSS_TICKS);
   localparam logic [CW-1:0] LIMIT = CW'(LOSS_TICKS);
   localparam logic [CW-1:0] PRE   = CW'(LOSS_TICKS - 1);

   generate
      if (LOSS_TICKS < 2) begin : g_bad_loss
         $error("LOSS_TICKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] quiet_cnt;

   assign hit     = ms_tick && !rx_evt && (quiet_cnt == PRE);
   assign expired = (quiet_cnt == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if (rx_evt) begin
         quiet_cnt <= '0;
      end else if (ms_tick && !expired) begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   AST_EVT_CLEARS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt |=> !expired); // R11
   AST_HIT_THEN_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> expired); // R6

endmodule

// File: rtl/tplm_link_fsm.sv
module tplm_link_fsm #(
   parameter int unsigned PASS_PULSES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_test_en,
   input  logic rx_packet,
   input  logic rx_link_pulse,
   input  logic hit,
   input  logic expired,
   output tplm_pkg::link_state_e state
);
   import tplm_pkg::*;

   localparam int unsigned PW = cnt_width(PASS_PULSES);
   localparam logic [PW-1:0] LAST_PULSE = PW'(PASS_PULSES - 1);

   generate
      if (PASS_PULSES < 1) begin : g_bad_pulses
         $error("PASS_PULSES must be at least 1");
      end
   endgenerate

   link_state_e state_d;
   logic [PW-1:0] pcnt, pcnt_d;

   always_comb begin
      state_d = state;
      pcnt_d  = pcnt;
      if (!link_test_en || rx_packet) begin
         state_d = LNK_PASS;
         pcnt_d  = '0;
      end else begin
         unique case (state)
            LNK_PASS: begin
               pcnt_d = '0;
               if ((hit || expired) && !rx_link_pulse) begin
                  state_d = LNK_FAIL;
               end
            end
            LNK_FAIL: begin
               if (rx_link_pulse) begin
                  if (pcnt == LAST_PULSE) begin
                     state_d = LNK_PASS;
                     pcnt_d  = '0;
                  end else begin
                     pcnt_d = pcnt + 1'b1;
                  end
               end else if (hit) begin
                  pcnt_d = '0;
               end
            end
            default: begin
               state_d = LNK_FAIL;
               pcnt_d  = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LNK_FAIL;
         pcnt  <= '0;
      end else begin
         state <= state_d;
         pcnt  <= pcnt_d;
      end
   end

   AST_PACKET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      rx_packet |=> (state == LNK_PASS)); // R8
   AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      !link_test_en |=> (state == LNK_PASS)); // R7
   AST_PULSE_HOLDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LNK_PASS) && rx_link_pulse |=> (state == LNK_PASS)); // R11

endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor #(
   parameter int unsigned IDLE_TICKS  = 16,
   parameter int unsigned LOSS_TICKS  = 100,
   parameter int unsigned PASS_PULSES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic tx_active,
   input  logic rx_packet,
   input  logic rx_link_pulse,
   input  logic link_test_en,
   input  logic pulse_tx_en,
   output logic pulse_req,
   output logic link_ok,
   output logic port_disable
);
   import tplm_pkg::*;

   generate
      if (IDLE_TICKS >= LOSS_TICKS) begin : g_bad_order
         $error("IDLE_TICKS must be below LOSS_TICKS");
      end
   endgenerate

   logic        rx_evt;
   logic        t_hit, t_expired;
   link_state_e st;

   assign rx_evt = rx_packet || rx_link_pulse;

   tplm_idle_pulser #(.IDLE_TICKS(IDLE_TICKS)) u_pulser (
      .clk         (clk),
      .rst_n       (rst_n),
      .ms_tick     (ms_tick),
      .tx_active   (tx_active),
      .pulse_tx_en (pulse_tx_en),
      .pulse_req   (pulse_req)
   );

   tplm_silence_timer #(.LOSS_TICKS(LOSS_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .rx_evt  (rx_evt),
      .hit     (t_hit),
      .expired (t_expired)
   );

   tplm_link_fsm #(.PASS_PULSES(PASS_PULSES)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .link_test_en  (link_test_en),
      .rx_packet     (rx_packet),
      .rx_link_pulse (rx_link_pulse),
      .hit           (t_hit),
      .expired       (t_expired),
      .state         (st)
   );

   assign link_ok      = (st == LNK_PASS);
   assign port_disable = (st == LNK_FAIL);

   AST_FAIL_NEEDS_TEST: assert property (@(posedge clk) disable iff (!rst_n)
      link_ok && !link_test_en |=> link_ok); // R7
   AST_DISABLE_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      port_disable != link_ok); // R6

endmodule

// File: tb/tb_tp_link_monitor.sv
module tb_tp_link_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS = 24;

   // row bits: tick tx pkt lp lten pten | exp_req exp_ok
   localparam logic [7:0] VEC [NROWS] = '{
      8'b0_0_0_1_1_1_0_0, 8'b0_0_0_1_1_1_0_0, 8'b0_0_0_1_1_1_0_0,
      8'b0_0_0_0_1_1_0_0, 8'b0_0_0_1_1_1_0_1, 8'b0_0_0_0_0_1_0_1,
      8'b0_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1, 8'b1_0_0_0_1_1_0_1,
      8'b1_0_0_0_1_1_1_1, 8'b0_0_0_0_1_1_0_1
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0, tx_active = 1'b0, rx_packet = 1'b0, rx_link_pulse = 1'b0;
   logic link_test_en = 1'b1, pulse_tx_en = 1'b1;
   logic pulse_req, link_ok, port_disable;
   int checks = 0;
   int errors = 0;

   tp_link_monitor dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .tx_active(tx_active),
      .rx_packet(rx_packet), .rx_link_pulse(rx_link_pulse),
      .link_test_en(link_test_en), .pulse_tx_en(pulse_tx_en),
      .pulse_req(pulse_req), .link_ok(link_ok), .port_disable(port_disable)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic t, input logic tx, input logic pk, input logic lp);
      ms_tick = t; tx_active = tx; rx_packet = pk; rx_link_pulse = lp;
      @(negedge clk);
      ms_tick = 0; tx_active = 0; rx_packet = 0; rx_link_pulse = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
   endtask

   function automatic string row_req(input int r);
      if (r < 5) return "R9";
      if (r < 7) return "R7";
      return "R2";
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      chk("R1 link_ok", link_ok, 1'b0);
      rst_n = 1'b1;
      chk("R1 port_disable", port_disable, 1'b1);
      chk("R1 pulse_req", pulse_req, 1'b0);

      for (int r = 0; r < NROWS; r++) begin
         link_test_en = VEC[r][3];
         pulse_tx_en  = VEC[r][2];
         cyc(VEC[r][7], VEC[r][6], VEC[r][5], VEC[r][4]);
         chk({row_req(r), " table pulse_req"}, pulse_req, VEC[r][1]);
         chk({row_req(r), " table link_ok"}, link_ok, VEC[r][0]);
      end
      link_test_en = 1'b1; pulse_tx_en = 1'b1;

      // R3: transmit activity restarts the idle count
      cyc(0, 1, 1, 0);
      ticks(10);
      cyc(0, 1, 0, 0);
      ticks(15);
      chk("R3 no req after 15", pulse_req, 1'b0);
      ticks(1);
      chk("R3 req after 16", pulse_req, 1'b1);
      cyc(0, 0, 0, 0);
      chk("R2 req one cycle", pulse_req, 1'b0);

      // R4: masked pulse transmission
      cyc(0, 1, 1, 0);
      pulse_tx_en = 1'b0;
      ticks(16);
      chk("R4 masked req", pulse_req, 1'b0);
      pulse_tx_en = 1'b1;

      // R6: loss timeout in link-pass
      cyc(0, 1, 1, 0);
      ticks(99);
      chk("R6 still up at 99", link_ok, 1'b1);
      ticks(1);
      chk("R6 down at 100", link_ok, 1'b0);
      chk("R6 port_disable", port_disable, 1'b1);

      // R5: pulses in link-fail
      cyc(0, 1, 0, 0);
      ticks(16);
      chk("R5 req in link-fail", pulse_req, 1'b1);

      // R10: gap restarts the pulse count
      pulses(3);
      ticks(100);
      chk("R10 fail after gap", link_ok, 1'b0);
      pulses(3);
      chk("R10 three after gap", link_ok, 1'b0);
      pulses(1);
      chk("R10 fourth after gap", link_ok, 1'b1);

      // R8: a packet leaves link-fail
      ticks(100);
      chk("R8 precondition fail", link_ok, 1'b0);
      cyc(0, 0, 1, 0);
      chk("R8 packet passes", link_ok, 1'b1);

      // R11: fourth pulse on the timeout tick, in link-fail
      ticks(100);
      pulses(3);
      ticks(99);
      cyc(1, 0, 0, 1);
      chk("R11 pulse with timeout fail", link_ok, 1'b1);

      // R11: pulse on the timeout tick, in link-pass
      ticks(99);
      cyc(1, 0, 0, 1);
      chk("R11 pulse with timeout pass", link_ok, 1'b1);
      ticks(99);
      chk("R11 timer restarted", link_ok, 1'b1);
      ticks(1);
      chk("R11 fail 100 later", link_ok, 1'b0);

      // R7: link test disabled
      link_test_en = 1'b0;
      cyc(0, 0, 0, 0);
      chk("R7 forced pass", link_ok, 1'b1);
      ticks(150);
      chk("R7 no fail when off", link_ok, 1'b1);
      link_test_en = 1'b1;
      cyc(0, 0, 0, 0);
      chk("R7 fail on reenable", link_ok, 1'b0);

      // R1: reset from link-pass
      cyc(0, 0, 1, 0);
      rst_n = 1'b0;
      cyc(0, 0, 0, 0);
      chk("R1 reset link_ok", link_ok, 1'b0);
      chk("R1 reset port_disable", port_disable, 1'b1);
      chk("R1 reset pulse_req", pulse_req, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule